// File: doc/BRIEF.md
# Shadowed Register Access Sequencer

This block sits between a host and a two-channel serial controller whose registers are reached through a pointer scheme. The host sees a flat space of register numbers. Write registers are 0 to 15, read registers are 16 to 31, and number 33 names the alternate option register. For each request the sequencer produces the needed series of strobes on the peripheral's control and data ports. A typical series is a pointer write on the control port, then the access itself. The sequencer holds every strobe back until a programmable recovery gap has passed since the previous one.

Most write registers cannot be read back on the peripheral. The sequencer therefore keeps a copy of each value it writes, and reads of those registers are answered from that copy with no bus traffic. Bit 0 of register 15 selects whether register 7 or the option register sits behind pointer 7. The sequencer keeps that bit correct by rewriting register 15 when needed, just before it touches either register. A read-modify-write request reads the stored copy, computes the new value and writes it in one uninterrupted transaction.

Top module: `shadow_reg_seq`

## Requirements
- R1: Only these numbers are legal. Writes: 0 to 15 and 33. Reads: 1 to 7, 9 to 15, 16 to 19, 22 to 24, 26 and 33. Read-modify-write: 1 to 7, 9 to 15 and 33. Any other request gives `rsp_err`=1 and `rsp_rdata`=0 in the cycle after acceptance, with no strobe.
- R2: At least GAP_CYCLES idle cycles separate any two `bus_stb` pulses. The first strobe of a request comes in the cycle after acceptance once that gap is met.
- R3: A write to register 0 is a single control-port write (`bus_data_sel`=0). A write to register 8 is a single data-port write (`bus_data_sel`=1). Neither one changes any stored copy, including the option-register copy.
- R4: A write to registers 1 to 6, 9 to 15 or 33 gives two control-port writes: first the pointer, then the value. The pointer is the register number, or 7 for register 33. The value is stored for later reads.
- R5: Before a write to register 7, if the stored register 15 has bit 0 = 1, the sequencer writes pointer 15 and then register 15 with bit 0 cleared. Before a write to register 33, it does the same with bit 0 set, but only if the bit is clear. The stored register 15 copy follows the change.
- R6: A value written to register 9 is masked to its low 6 bits, and a value written to register 14 to its low 5 bits. The mask applies both on the bus and in the stored copy. Register 9 has one copy shared by both channels. All other copies are kept per channel.
- R7: A read of registers 1 to 7, 9 to 15 or 33 returns the stored copy. `rsp_valid` rises in the cycle after acceptance, and there is no strobe.
- R8: Read 16 is a direct control-port read and read 24 is a direct data-port read. Reads 17, 22, 23 and 26 write pointer (number minus 16), then read the control port. Read 19 always uses channel 0 with pointer 3. Read 18 always uses channel 1 with pointer 2. The response data is the byte on `bus_rdata` at the read strobe.
- R9: After the last strobe of a transaction in cycle t, `rsp_valid` is 1 in cycle t+GAP_CYCLES+2. If `req_nodelay`=1 it is 1 in cycle t+1 instead, and the gap still applies to the next strobe.
- R10: A read-modify-write writes ((stored AND `req_mask`) OR `req_wdata`), with the R6 masks applied, using the full R4/R5 sequence. The response returns the old stored value.
- R11: `req_ready` is 1 only when idle and out of reset. `rsp_valid` is a one-cycle pulse. After reset all stored copies read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_chan | input | 1 | Channel of the request |
| req_num | input | 6 | Register number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rmw | input | 1 | Read-modify-write request |
| req_nodelay | input | 1 | Skip the trailing recovery gap |
| req_wdata | input | 8 | Write value, or OR term for read-modify-write |
| req_mask | input | 8 | AND mask for read-modify-write |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Illegal request |
| rsp_rdata | output | 8 | Read data, or old value for read-modify-write |
| bus_stb | output | 1 | One-cycle peripheral access strobe |
| bus_chan | output | 1 | Peripheral channel |
| bus_data_sel | output | 1 | 0 = control port, 1 = data port |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid during a read strobe |

## Verification
Two things can line up in the same cycle. One is the early response of a transaction that skips its trailing gap. The other is the acceptance of the next request while the recovery counter is still running. The bench provokes this by issuing `req_nodelay` writes and then a bus request at once. Its cycle model then expects the first new strobe exactly GAP_CYCLES+1 cycles after the old one, not the cycle after acceptance. The option-bit rewrite for registers 7 and 33 is judged the same way, by the order, contents and spacing of every strobe against the model's queue.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int unsigned DW = 8;
  localparam logic [5:0] NUM_ALT_OPT = 6'd33;
  localparam logic [3:0] SLOT_ALT_OPT = 4'd8;
  localparam logic [3:0] SLOT_SELECT = 4'd15;

  typedef enum logic [1:0] {OP_ERR, OP_SHADOW, OP_BUS} op_e;
  typedef enum logic [1:0] {CH_KEEP, CH_FORCE_A, CH_FORCE_B} chsel_e;
  typedef enum logic [1:0] {OPT_NONE, OPT_CLEAR, OPT_SET} optfix_e;
  typedef enum logic [2:0] {S_IDLE, S_FIX_PTR, S_FIX_VAL, S_PTR, S_ACC, S_TAIL, S_DONE} state_e;

  typedef struct packed {
    op_e           op;
    logic          wr;
    logic          ptr;
    logic [3:0]    ptr_val;
    logic          data_port;
    chsel_e        chsel;
    optfix_e       opt;
    logic          sh_wr;
    logic          sh_shared;
    logic [3:0]    slot;
    logic [DW-1:0] wmask;
  } dec_t;

  typedef struct packed {
    logic [3:0]    ptr_val;
    logic          data_port;
    logic          wr;
    logic [DW-1:0] val;
    logic          sh_wr;
    logic          sh_shared;
    logic [3:0]    slot;
    logic          nodelay;
    logic [DW-1:0] fixval;
  } xact_t;
endpackage

// File: rtl/regseq_decode.sv
module regseq_decode
  import regseq_pkg::*;
(
  input  logic [5:0] num,
  input  logic       wr,
  input  logic       rmw,
  output dec_t       dec
);
  logic keeps_copy;

  always_comb begin
    keeps_copy = ((num >= 6'd1) && (num <= 6'd7)) || ((num >= 6'd9) && (num <= 6'd15)) ||
                 (num == NUM_ALT_OPT);
    dec           = '0;
    dec.op        = OP_ERR;
    dec.chsel     = CH_KEEP;
    dec.opt       = OPT_NONE;
    dec.wmask     = '1;
    dec.slot      = (num == NUM_ALT_OPT) ? SLOT_ALT_OPT : num[3:0];
    dec.sh_shared = (num == 6'd9);
    if (wr || rmw) begin
      dec.wr = 1'b1;
      if (keeps_copy) begin
        dec.op      = OP_BUS;
        dec.ptr     = 1'b1;
        dec.ptr_val = (num == NUM_ALT_OPT) ? 4'd7 : num[3:0];
        dec.sh_wr   = 1'b1;
        if (num == 6'd7)        dec.opt = OPT_CLEAR;
        if (num == NUM_ALT_OPT) dec.opt = OPT_SET;
        if (num == 6'd9)        dec.wmask = 8'h3F;
        if (num == 6'd14)       dec.wmask = 8'h1F;
      end else if (!rmw && ((num == 6'd0) || (num == 6'd8))) begin
        dec.op        = OP_BUS;
        dec.data_port = num[3];
      end
    end else if (keeps_copy) begin
      dec.op = OP_SHADOW;
    end else begin
      case (num)
        6'd16, 6'd24: begin
          dec.op        = OP_BUS;
          dec.data_port = num[3];
        end
        6'd17, 6'd22, 6'd23, 6'd26: begin
          dec.op      = OP_BUS;
          dec.ptr     = 1'b1;
          dec.ptr_val = num[3:0];
        end
        6'd19: begin
          dec.op      = OP_BUS;
          dec.ptr     = 1'b1;
          dec.ptr_val = 4'd3;
          dec.chsel   = CH_FORCE_A;
        end
        6'd18: begin
          dec.op      = OP_BUS;
          dec.ptr     = 1'b1;
          dec.ptr_val = 4'd2;
          dec.chsel   = CH_FORCE_B;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regseq_shadow.sv
module regseq_shadow
  import regseq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [$clog2(NCH)-1:0] wchan,
  input  logic                   wshared,
  input  logic [3:0]             wslot,
  input  logic [DW-1:0]          wdata,
  input  logic [$clog2(NCH)-1:0] rchan,
  input  logic                   rshared,
  input  logic [3:0]             rslot,
  output logic [DW-1:0]          rdata,
  input  logic [$clog2(NCH)-1:0] ochan,
  output logic [DW-1:0]          opt_reg
);
  localparam int CW = $clog2(NCH);

  logic [NCH-1:0][15:0][DW-1:0] bank;
  logic [DW-1:0]                shared_q;
  logic                         shared_en;

  assign shared_en = we && wshared;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shared_q <= '0;
    else if (shared_en) shared_q <= wdata;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [15:0][DW-1:0] regs_q;
    logic                ch_en;
    assign ch_en   = we && !wshared && (wchan == CW'(g));
    assign bank[g] = regs_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q <= '0;
      else if (ch_en) regs_q[wslot] <= wdata;
    end
    AST_SLOT14_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      regs_q[14][7:5] == 3'b000); // R6
  end

  assign rdata   = rshared ? shared_q : bank[rchan][rslot];
  assign opt_reg = bank[ochan][SLOT_SELECT];

  AST_SHARED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    shared_q[7:6] == 2'b00); // R6
endmodule

// File: rtl/regseq_pacer.sv
module regseq_pacer #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic ok
);
  localparam int CW = $clog2(GAP + 2);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (stb)                cnt_d = CW'(GAP);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ok = (cnt_q == '0);
endmodule

// File: rtl/shadow_reg_seq.sv
module shadow_reg_seq
  import regseq_pkg::*;
#(
  parameter int GAP_CYCLES = 4,
  parameter int NCH        = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [$clog2(NCH)-1:0] req_chan,
  input  logic [5:0]             req_num,
  input  logic                   req_write,
  input  logic                   req_rmw,
  input  logic                   req_nodelay,
  input  logic [7:0]             req_wdata,
  input  logic [7:0]             req_mask,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [7:0]             rsp_rdata,
  output logic                   bus_stb,
  output logic [$clog2(NCH)-1:0] bus_chan,
  output logic                   bus_data_sel,
  output logic                   bus_we,
  output logic [7:0]             bus_wdata,
  input  logic [7:0]             bus_rdata
);
  localparam int CW  = $clog2(NCH);
  localparam int GCW = $clog2(GAP_CYCLES + 2);

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  state_e          state_q, state_d;
  xact_t           x_q, x_d;
  logic [CW-1:0]   chan_q, chan_d;
  logic            err_q, err_d;
  logic [DW-1:0]   rdat_q, rdat_d;
  dec_t            dec;
  logic            pace_ok, fix_need;
  logic            sh_we, sh_wshared;
  logic [3:0]      sh_wslot;
  logic [DW-1:0]   sh_wdata, sh_rdata, sh_opt;
  logic [CW-1:0]   opt_chan;

  regseq_decode u_decode (
    .num (req_num), .wr (req_write), .rmw (req_rmw), .dec (dec)
  );

  assign opt_chan = (state_q == S_IDLE) ? req_chan : chan_q;

  regseq_shadow #(.NCH(NCH)) u_shadow (
    .clk (clk), .rst_n (srst_n),
    .we (sh_we), .wchan (chan_q), .wshared (sh_wshared), .wslot (sh_wslot), .wdata (sh_wdata),
    .rchan (req_chan), .rshared (dec.sh_shared), .rslot (dec.slot), .rdata (sh_rdata),
    .ochan (opt_chan), .opt_reg (sh_opt)
  );

  regseq_pacer #(.GAP(GAP_CYCLES)) u_pacer (
    .clk (clk), .rst_n (srst_n), .stb (bus_stb), .ok (pace_ok)
  );

  always_comb begin
    state_d      = state_q;
    x_d          = x_q;
    chan_d       = chan_q;
    err_d        = err_q;
    rdat_d       = rdat_q;
    req_ready    = (state_q == S_IDLE) && srst_n;
    bus_stb      = 1'b0;
    bus_data_sel = 1'b0;
    bus_we       = 1'b1;
    bus_wdata    = '0;
    sh_we        = 1'b0;
    sh_wshared   = x_q.sh_shared;
    sh_wslot     = x_q.slot;
    sh_wdata     = x_q.val;
    fix_need     = ((dec.opt == OPT_CLEAR) && sh_opt[0]) || ((dec.opt == OPT_SET) && !sh_opt[0]);
    case (state_q)
      S_IDLE: if (req_valid && req_ready) begin
        err_d  = 1'b0;
        rdat_d = '0;
        case (dec.op)
          OP_ERR: begin
            err_d   = 1'b1;
            state_d = S_DONE;
          end
          OP_SHADOW: begin
            rdat_d  = sh_rdata;
            state_d = S_DONE;
          end
          default: begin
            chan_d = (dec.chsel == CH_FORCE_A) ? '0 :
                     (dec.chsel == CH_FORCE_B) ? CW'(1) : req_chan;
            x_d.ptr_val   = dec.ptr_val;
            x_d.data_port = dec.data_port;
            x_d.wr        = dec.wr;
            x_d.val       = (req_rmw ? ((sh_rdata & req_mask) | req_wdata) : req_wdata) & dec.wmask;
            x_d.sh_wr     = dec.sh_wr;
            x_d.sh_shared = dec.sh_shared;
            x_d.slot      = dec.slot;
            x_d.nodelay   = req_nodelay;
            x_d.fixval    = sh_opt ^ 8'h01;
            if (req_rmw) rdat_d = sh_rdata;
            state_d = fix_need ? S_FIX_PTR : (dec.ptr ? S_PTR : S_ACC);
          end
        endcase
      end
      S_FIX_PTR: if (pace_ok) begin
        bus_stb   = 1'b1;
        bus_wdata = {4'd0, SLOT_SELECT};
        state_d   = S_FIX_VAL;
      end
      S_FIX_VAL: if (pace_ok) begin
        bus_stb    = 1'b1;
        bus_wdata  = x_q.fixval;
        sh_we      = 1'b1;
        sh_wshared = 1'b0;
        sh_wslot   = SLOT_SELECT;
        sh_wdata   = x_q.fixval;
        state_d    = S_PTR;
      end
      S_PTR: if (pace_ok) begin
        bus_stb   = 1'b1;
        bus_wdata = {4'd0, x_q.ptr_val};
        state_d   = S_ACC;
      end
      S_ACC: if (pace_ok) begin
        bus_stb      = 1'b1;
        bus_data_sel = x_q.data_port;
        bus_we       = x_q.wr;
        bus_wdata    = x_q.wr ? x_q.val : '0;
        if (x_q.wr) sh_we  = x_q.sh_wr;
        else        rdat_d = bus_rdata;
        state_d = x_q.nodelay ? S_DONE : S_TAIL;
      end
      S_TAIL: if (pace_ok) state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= S_IDLE;
      x_q     <= '0;
      chan_q  <= '0;
      err_q   <= 1'b0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      x_q     <= x_d;
      chan_q  <= chan_d;
      err_q   <= err_d;
      rdat_q  <= rdat_d;
    end
  end

  assign rsp_valid = (state_q == S_DONE);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdat_q;
  assign bus_chan  = chan_q;

  logic [GCW-1:0] gap_seen_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)                              gap_seen_q <= GCW'(GAP_CYCLES);
    else if (bus_stb)                         gap_seen_q <= '0;
    else if (gap_seen_q != GCW'(GAP_CYCLES))  gap_seen_q <= gap_seen_q + 1'b1;
  end

  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!srst_n)
    bus_stb |-> (gap_seen_q == GCW'(GAP_CYCLES))); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid |-> !req_ready); // R11
  AST_LOCAL_NO_BUS: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready && (dec.op != OP_BUS)) |=> (rsp_valid && !bus_stb)); // R7
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R1
  AST_SELECT_BIT_READY: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_stb && (state_q == S_PTR) && x_q.wr && x_q.sh_wr && (x_q.ptr_val == 4'd7)) |->
    (sh_opt[0] == (x_q.slot == SLOT_ALT_OPT))); // R5
endmodule

// File: tb/shadow_reg_seq_bench.sv
module shadow_reg_seq_bench;
  localparam int GAP = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, req_valid, req_ready, req_chan, req_write, req_rmw, req_nodelay;
  logic [5:0] req_num;
  logic [7:0] req_wdata, req_mask, rsp_rdata, bus_wdata, bus_rdata;
  logic       rsp_valid, rsp_err, bus_stb, bus_chan, bus_data_sel, bus_we;

  shadow_reg_seq #(.GAP_CYCLES(GAP), .NCH(2)) u_shadow_reg_seq (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_chan (req_chan), .req_num (req_num), .req_write (req_write), .req_rmw (req_rmw),
    .req_nodelay (req_nodelay), .req_wdata (req_wdata), .req_mask (req_mask),
    .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
    .bus_stb (bus_stb), .bus_chan (bus_chan), .bus_data_sel (bus_data_sel),
    .bus_we (bus_we), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
  );

  // bench peripheral: read byte depends on channel, port and a read counter
  logic [5:0] rd_seq = '0;
  assign bus_rdata = 8'h3C ^ {bus_chan, bus_data_sel, rd_seq};
  always @(posedge clk) if (bus_stb && !bus_we) rd_seq <= rd_seq + 6'd1;

  int checks = 0, errors = 0, cyc = 0;
  bit model_on = 0;

  typedef struct { bit ch; bit ds; bit we; logic [7:0] wd; } acc_t;
  acc_t exp_q[$];
  logic [7:0] msh [2][16];
  logic [7:0] msh9;
  int due = 0, rsp_due = -1, last_stb = -100;
  bit exp_err, m_nd;
  logic [7:0] exp_data;
  string ttag = "R11", cur_tag = "R11";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] getsh(bit c, int n);
    if (n == 9) return msh9;
    if (n == 33) return msh[c][8];
    return msh[c][n];
  endfunction

  task automatic setsh(bit c, int n, logic [7:0] v);
    if (n == 9) msh9 = v;
    else if (n == 33) msh[c][8] = v;
    else msh[c][n] = v;
  endtask

  task automatic push(bit c, bit ds, bit we, logic [7:0] wd);
    acc_t a;
    a.ch = c; a.ds = ds; a.we = we; a.wd = wd;
    exp_q.push_back(a);
  endtask

  task automatic plan(bit c, int n, bit wr, bit rmw, bit nd, logic [7:0] wd, logic [7:0] mk);
    bit keep;
    logic [7:0] cur, nv;
    keep = (n >= 1 && n <= 7) || (n >= 9 && n <= 15) || n == 33;
    exp_err = 0; exp_data = 0; m_nd = nd;
    if (wr || rmw) begin
      if (keep) begin
        cur = getsh(c, n);
        nv = rmw ? ((cur & mk) | wd) : wd;
        if (n == 9) nv &= 8'h3F;
        if (n == 14) nv &= 8'h1F;
        if (rmw) exp_data = cur;
        if (n == 7 && msh[c][15][0]) begin
          push(c, 0, 1, 8'd15); msh[c][15][0] = 1'b0; push(c, 0, 1, msh[c][15]);
        end
        if (n == 33 && !msh[c][15][0]) begin
          push(c, 0, 1, 8'd15); msh[c][15][0] = 1'b1; push(c, 0, 1, msh[c][15]);
        end
        push(c, 0, 1, (n == 33) ? 8'd7 : 8'(n));
        push(c, 0, 1, nv);
        setsh(c, n, nv);
      end else if (!rmw && n == 0) push(c, 0, 1, wd);
      else if (!rmw && n == 8) push(c, 1, 1, wd);
      else exp_err = 1;
    end else if (keep) exp_data = getsh(c, n);
    else begin
      case (n)
        16: push(c, 0, 0, 0);
        24: push(c, 1, 0, 0);
        17, 22, 23, 26: begin push(c, 0, 1, 8'(n - 16)); push(c, 0, 0, 0); end
        19: begin push(0, 0, 1, 8'd3); push(0, 0, 0, 0); end
        18: begin push(1, 0, 1, 8'd2); push(1, 0, 0, 0); end
        default: exp_err = 1;
      endcase
    end
    if (exp_q.size() == 0) rsp_due = cyc + 1;
    else due = (cyc + 1 > last_stb + GAP + 1) ? cyc + 1 : last_stb + GAP + 1;
  endtask

  // cycle model compared on every clock, sampled away from the active edge
  always @(negedge clk) if (model_on) begin
    bit exp_stb;
    acc_t a;
    cyc++;
    exp_stb = (exp_q.size() > 0) && (cyc == due);
    chk(bus_stb == exp_stb, "R2", {ttag, " strobe timing"}, bus_stb, exp_stb);
    if (bus_stb && exp_q.size() > 0) begin
      a = exp_q.pop_front();
      chk(bus_chan == a.ch, ttag, "bus_chan", bus_chan, a.ch);
      chk(bus_data_sel == a.ds, ttag, "bus_data_sel", bus_data_sel, a.ds);
      chk(bus_we == a.we, ttag, "bus_we", bus_we, a.we);
      if (a.we) chk(bus_wdata == a.wd, ttag, "bus_wdata", bus_wdata, a.wd);
      else exp_data = 8'h3C ^ {a.ch, a.ds, rd_seq};
      last_stb = cyc;
      if (exp_q.size() == 0) rsp_due = m_nd ? cyc + 1 : cyc + GAP + 2; // R9
      else due = cyc + GAP + 1;
    end
    chk(rsp_valid == (cyc == rsp_due), "R9", {ttag, " response timing"}, rsp_valid, cyc == rsp_due);
    if (rsp_valid && cyc == rsp_due) begin
      chk(rsp_err == exp_err, ttag, "rsp_err", rsp_err, exp_err);
      chk(rsp_rdata == exp_data, ttag, "rsp_rdata", rsp_rdata, exp_data);
    end
    if (req_valid && req_ready) begin
      ttag = cur_tag;
      plan(req_chan, int'(req_num), req_write, req_rmw, req_nodelay, req_wdata, req_mask);
    end
  end

  task automatic xact(bit c, int n, bit wr, bit rmw, bit nd, logic [7:0] wd, logic [7:0] mk, string tag);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_chan = c; req_num = 6'(n); req_write = wr; req_rmw = rmw; req_nodelay = nd;
    req_wdata = wd; req_mask = mk; cur_tag = tag; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr_reg(bit c, int n, logic [7:0] v, string tag);
    xact(c, n, 1, 0, 0, v, 8'h00, tag);
  endtask

  task automatic rd_reg(bit c, int n, string tag);
    xact(c, n, 0, 0, 0, 8'h00, 8'h00, tag);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int s = 0; s < 16; s++) msh[c][s] = 8'h00;
    msh9 = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_chan = 0; req_num = '0; req_write = 0;
    req_rmw = 0; req_nodelay = 0; req_wdata = '0; req_mask = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1'b0, "R11", "ready in reset", req_ready, 0);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", rsp_valid, 0);
    chk(bus_stb == 1'b0, "R11", "bus_stb in reset", bus_stb, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    @(negedge clk); model_on = 1;

    rd_reg(0, 3, "R11");                       // reset copy is zero
    wr_reg(0, 3, 8'hA5, "R4");
    rd_reg(0, 3, "R7");
    rd_reg(1, 3, "R7");                        // other channel untouched
    wr_reg(1, 33, 8'h5B, "R5");                // option bit set first
    wr_reg(1, 0, 8'h10, "R3");
    wr_reg(1, 8, 8'h77, "R3");
    rd_reg(1, 33, "R3");                       // data-port write left copy alone
    rd_reg(0, 0, "R1");
    wr_reg(0, 9, 8'hFF, "R6");
    rd_reg(1, 9, "R6");                        // shared copy
    wr_reg(1, 14, 8'hFF, "R6");
    rd_reg(1, 14, "R6");
    rd_reg(0, 14, "R6");
    wr_reg(0, 15, 8'h81, "R4");
    wr_reg(0, 7, 8'h7E, "R5");                 // bit 0 cleared first
    rd_reg(0, 15, "R5");
    wr_reg(0, 33, 8'h42, "R5");                // bit 0 set first
    wr_reg(0, 33, 8'h43, "R5");                // no rewrite needed
    rd_reg(0, 33, "R7");
    rd_reg(0, 7, "R7");
    rd_reg(1, 16, "R8");
    rd_reg(0, 24, "R8");
    rd_reg(1, 17, "R8");
    rd_reg(0, 26, "R8");
    rd_reg(1, 19, "R8");
    rd_reg(0, 18, "R8");
    rd_reg(0, 20, "R1");
    wr_reg(0, 16, 8'h11, "R1");
    wr_reg(1, 40, 8'h22, "R1");
    xact(0, 0, 0, 1, 0, 8'h01, 8'hFF, "R1");   // rmw on register 0
    xact(0, 5, 1, 0, 1, 8'h3A, 8'h00, "R9");   // no trailing gap
    xact(1, 6, 1, 0, 1, 8'h3B, 8'h00, "R9");   // first strobe waits for gap
    rd_reg(1, 23, "R2");
    wr_reg(0, 12, 8'hF0, "R10");
    xact(0, 12, 0, 1, 0, 8'h01, 8'h3C, "R10");
    rd_reg(0, 12, "R10");
    xact(1, 14, 0, 1, 0, 8'hE0, 8'hFF, "R10");
    rd_reg(1, 14, "R10");
    xact(1, 7, 0, 1, 1, 8'h80, 8'h0F, "R10");  // rmw clears option bit on ch1
    rd_reg(1, 15, "R10");

    repeat (3 * GAP + 10) @(posedge clk);
    chk(exp_q.size() == 0, "R2", "pending strobes", exp_q.size(), 0);
    finish_run();
  end
endmodule